// File: doc/BRIEF.md
# Freefall and Motion Event Detector

This block watches a stream of signed three-axis acceleration samples and decides, sample by sample, whether an inertial event is taking place. In motion mode an event is present when any enabled axis exceeds a programmable magnitude threshold. In freefall mode an event is present when every enabled axis stays at or below that threshold. A debounce counter then filters the raw condition. The counter either steps down or clears on a sample that does not qualify. It saturates at a programmable limit.

The block reports an event-active flag, a per-axis high-g flag and a per-axis negative-sign flag. It also raises an interrupt request that mirrors the event-active flag. With latching off, the flags track each new sample. With latching on, they freeze once an event is recorded and stay that way until the host issues a source read strobe. Motion mode can take its samples from a high-pass filtered stream. Freefall mode always uses the unfiltered stream.

Top module: `freefall_motion_det`

## Requirements
- R1: Only axes whose bit is set in `cfg_axis_en` (bit 0 X, bit 1 Y, bit 2 Z) take part in detection. A disabled axis never sets its high-g or negative flag and never blocks or causes an event.
- R2: An axis is high-g when its magnitude |s|, shifted right by DW-1-TW bits (6 at default widths), is strictly greater than `cfg_thresh`. Otherwise it is low-g, so equality counts as low-g. The most negative code has magnitude 2^(DW-1).
- R3: With `cfg_motion`=1 the raw condition is the OR of high-g over the enabled axes. With `cfg_motion`=0 it is the AND of low-g over the enabled axes. When no axis is enabled there is no condition.
- R4: Freefall mode always compares `raw_smp`. Motion mode compares `hpf_smp` when `cfg_use_hpf`=1, and `raw_smp` otherwise.
- R5: Each axis reports a high-g flag. It also reports a negative flag, which is the sign bit of the compared sample and is set only when that axis is high-g and enabled.
- R6: With `cfg_latch`=0, every valid sample rewrites the event flag and the per-axis flags, and `src_read` has no effect.
- R7: With `cfg_latch`=1, once the event flag is set, all flags hold until `src_read` clears them to zero. A read in the same cycle as a sample clears first, and that sample then updates the cleared flags.
- R8: The debounced event is asserted on a qualifying sample that brings the counter to `cfg_dbnc_limit`. The counter counts up by one per qualifying sample and saturates at the limit. A limit of 0 makes every qualifying sample an event.
- R9: With `cfg_dbnc_clear`=1, a non-qualifying sample resets the counter to zero.
- R10: With `cfg_dbnc_clear`=0, a non-qualifying sample decrements the counter, stopping at zero.
- R11: `irq` equals `evt_active`. All outputs change on the clock edge that captures the sample, one cycle after `smp_valid` is presented.
- R12: Synchronous reset clears the counter and all outputs to zero.
- R13: In a cycle with no valid sample and no effective read, all outputs keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_motion | input | 1 | 1 selects motion (OR of high-g), 0 selects freefall (AND of low-g) |
| cfg_use_hpf | input | 1 | Motion mode takes the filtered stream |
| cfg_axis_en | input | 3 | Axis participation, bit 0 X, bit 1 Y, bit 2 Z |
| cfg_thresh | input | TW (7) | Magnitude threshold |
| cfg_latch | input | 1 | Hold flags until read |
| cfg_dbnc_clear | input | 1 | 1 clears the counter on a miss, 0 decrements it |
| cfg_dbnc_limit | input | CW (8) | Consecutive-sample count needed for an event |
| smp_valid | input | 1 | Sample strobe |
| raw_smp | input | 3xDW (3x14) | Unfiltered signed samples, index 0 X, 1 Y, 2 Z |
| hpf_smp | input | 3xDW (3x14) | High-pass filtered signed samples, same order |
| src_read | input | 1 | Source register read strobe |
| evt_active | output | 1 | Debounced event flag |
| axis_high | output | 3 | Per-axis high-g flags |
| axis_neg | output | 3 | Per-axis negative-sign flags |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value does not show at once. It surfaces as an event that arrives one or more samples early or late, and at the latest at the first qualifying sample after the counter reaches the limit. Wrong latch state shows up at the next sample after an event, as a flag that moves when it should hold, or at the first read, as a flag that survives it. Wrong comparison or source selection is visible on the per-axis flags at the very next sample. The bench therefore compares every output after every sample against a model, across long random runs of configuration and samples placed close to the threshold.

// File: rtl/fmd_pkg.sv
`timescale 1ns/1ps
package fmd_pkg;
    localparam int AXES = 3;

    typedef enum logic {
        DBN_DECREMENT = 1'b0,
        DBN_CLEAR     = 1'b1
    } dbn_mode_e;

    typedef struct packed {
        logic            active;
        logic [AXES-1:0] high;
        logic [AXES-1:0] neg;
    } evt_flags_t;

    // Raw combination rule across axes.
    function automatic logic qualify(input logic motion,
                                     input logic [AXES-1:0] en,
                                     input logic [AXES-1:0] above);
        if (motion)
            return |(above & en);
        else
            return (en != '0) && ((above & en) == '0);
    endfunction
endpackage

// File: rtl/fmd_axis_cmp.sv
`timescale 1ns/1ps
module fmd_axis_cmp #(
    parameter int DW = 14,
    parameter int TW = 7
) (
    input  logic [DW-1:0] smp,
    input  logic [TW-1:0] thr,
    output logic          above,
    output logic          sign
);
    localparam int SH = DW - 1 - TW;
    localparam int MW = TW + 1;

    logic [DW-1:0] mag;
    logic [MW-1:0] scaled;

    always_comb begin
        mag    = smp[DW-1] ? (~smp + 1'b1) : smp;
        scaled = mag[DW-1:SH];
        above  = scaled > {1'b0, thr};
        sign   = smp[DW-1];
    end
endmodule

// File: rtl/fmd_debounce.sv
`timescale 1ns/1ps
module fmd_debounce
    import fmd_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          cond,
    input  dbn_mode_e     mode,
    input  logic [CW-1:0] limit,
    output logic          event_now,
    output logic [CW-1:0] cnt_q
);
    logic [CW-1:0] cnt_d;

    always_comb begin
        if (cond)
            cnt_d = (cnt_q < limit) ? cnt_q + 1'b1 : limit;
        else if (mode == DBN_CLEAR)
            cnt_d = '0;
        else
            cnt_d = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
        event_now = cond && (cnt_d >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (valid)
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fmd_flags.sv
`timescale 1ns/1ps
module fmd_flags
    import fmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       rd,
    input  logic       latch,
    input  evt_flags_t live,
    output evt_flags_t flags_q
);
    evt_flags_t base;
    evt_flags_t flags_d;

    always_comb begin
        base    = (latch && rd) ? '0 : flags_q;
        flags_d = base;
        if (valid && !(latch && base.active))
            flags_d = live;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end
endmodule

// File: rtl/freefall_motion_det.sv
`timescale 1ns/1ps
module freefall_motion_det
    import fmd_pkg::*;
#(
    parameter int DW = 14,
    parameter int TW = 7,
    parameter int CW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_motion,
    input  logic                    cfg_use_hpf,
    input  logic [AXES-1:0]         cfg_axis_en,
    input  logic [TW-1:0]           cfg_thresh,
    input  logic                    cfg_latch,
    input  logic                    cfg_dbnc_clear,
    input  logic [CW-1:0]           cfg_dbnc_limit,
    input  logic                    smp_valid,
    input  logic [AXES-1:0][DW-1:0] raw_smp,
    input  logic [AXES-1:0][DW-1:0] hpf_smp,
    input  logic                    src_read,
    output logic                    evt_active,
    output logic [AXES-1:0]         axis_high,
    output logic [AXES-1:0]         axis_neg,
    output logic                    irq
);
    logic            take_hpf;
    logic [AXES-1:0] above;
    logic [AXES-1:0] sign;
    logic            cond;
    logic            deb_evt;
    logic [CW-1:0]   dbn_cnt;
    evt_flags_t      live;
    evt_flags_t      flags_q;

    assign take_hpf = cfg_motion && cfg_use_hpf;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic [DW-1:0] sel;
        assign sel = take_hpf ? hpf_smp[a] : raw_smp[a];
        fmd_axis_cmp #(.DW(DW), .TW(TW)) u_cmp (
            .smp   (sel),
            .thr   (cfg_thresh),
            .above (above[a]),
            .sign  (sign[a])
        );
    end

    assign cond = qualify(cfg_motion, cfg_axis_en, above);

    fmd_debounce #(.CW(CW)) u_dbn (
        .clk       (clk),
        .rst       (rst),
        .valid     (smp_valid),
        .cond      (cond),
        .mode      (cfg_dbnc_clear ? DBN_CLEAR : DBN_DECREMENT),
        .limit     (cfg_dbnc_limit),
        .event_now (deb_evt),
        .cnt_q     (dbn_cnt)
    );

    always_comb begin
        live.active = deb_evt;
        live.high   = above & cfg_axis_en;
        live.neg    = above & cfg_axis_en & sign;
    end

    fmd_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .valid   (smp_valid),
        .rd      (src_read),
        .latch   (cfg_latch),
        .live    (live),
        .flags_q (flags_q)
    );

    assign evt_active = flags_q.active;
    assign axis_high  = flags_q.high;
    assign axis_neg   = flags_q.neg;
    assign irq        = flags_q.active;
endmodule

// File: rtl/fmd_checker.sv
`timescale 1ns/1ps
module fmd_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_latch,
    input logic [2:0]    cfg_axis_en,
    input logic          smp_valid,
    input logic          src_read,
    input logic          evt_active,
    input logic [2:0]    axis_high,
    input logic [2:0]    axis_neg,
    input logic [CW-1:0] dbn_cnt
);
    // R5: a negative flag never appears without its high-g flag
    a_r5_neg_needs_high: assert property (@(posedge clk) disable iff (rst)
        (axis_neg & ~axis_high) == 3'b000);

    // R1: in tracking mode a disabled axis reports nothing
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !cfg_latch) |=> ((axis_high & ~$past(cfg_axis_en)) == 3'b000));

    // R13 and R6: outputs hold without a sample or an effective read
    a_r13_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && (!src_read || !cfg_latch)) |=>
            ($stable(evt_active) && $stable(axis_high) && $stable(axis_neg)));

    // R7: a latched event survives until a read
    a_r7_latched_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_latch && evt_active && !src_read) |=> evt_active);

    // R7: a read without a sample clears everything in latch mode
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg_latch && src_read && !smp_valid) |=>
            (!evt_active && axis_high == 3'b000 && axis_neg == 3'b000));

    // R8: the counter climbs by at most one step per cycle
    a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
        {1'b0, dbn_cnt} <= {1'b0, $past(dbn_cnt)} + 1'b1);

    // R10: the counter moves only on a valid sample
    a_r10_cnt_on_sample: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(dbn_cnt));
endmodule

bind freefall_motion_det fmd_checker #(.CW(CW)) u_fmd_checker (
    .clk         (clk),
    .rst         (rst),
    .cfg_latch   (cfg_latch),
    .cfg_axis_en (cfg_axis_en),
    .smp_valid   (smp_valid),
    .src_read    (src_read),
    .evt_active  (evt_active),
    .axis_high   (axis_high),
    .axis_neg    (axis_neg),
    .dbn_cnt     (dbn_cnt)
);

// File: tb/test_freefall_motion_det.sv
`timescale 1ns/1ps
module test_freefall_motion_det;
    localparam int DW = 14;
    localparam int TW = 7;
    localparam int CW = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_motion = 1'b0, cfg_use_hpf = 1'b0;
    logic [2:0]         cfg_axis_en = 3'b000;
    logic [TW-1:0]      cfg_thresh = '0;
    logic               cfg_latch = 1'b0, cfg_dbnc_clear = 1'b0;
    logic [CW-1:0]      cfg_dbnc_limit = '0;
    logic               smp_valid = 1'b0, src_read = 1'b0;
    logic [2:0][DW-1:0] raw_smp = '0, hpf_smp = '0;
    logic               evt_active, irq;
    logic [2:0]         axis_high, axis_neg;

    int n_checks = 0, n_fail = 0;
    int m_cnt = 0;
    bit m_ea = 0;
    bit [2:0] m_hi = 0, m_neg = 0;

    always #5 clk = ~clk;

    freefall_motion_det #(.DW(DW), .TW(TW), .CW(CW)) i_freefall_motion_det (
        .clk(clk), .rst(rst), .cfg_motion(cfg_motion), .cfg_use_hpf(cfg_use_hpf),
        .cfg_axis_en(cfg_axis_en), .cfg_thresh(cfg_thresh), .cfg_latch(cfg_latch),
        .cfg_dbnc_clear(cfg_dbnc_clear), .cfg_dbnc_limit(cfg_dbnc_limit),
        .smp_valid(smp_valid), .raw_smp(raw_smp), .hpf_smp(hpf_smp),
        .src_read(src_read), .evt_active(evt_active), .axis_high(axis_high),
        .axis_neg(axis_neg), .irq(irq)
    );

    function automatic int scaled_of(input logic [DW-1:0] s);
        int v = int'($signed(s));
        if (v < 0) v = -v;
        return v >> (DW - 1 - TW);
    endfunction

    // Model of R1..R13, updated at the capturing edge
    task automatic model_update();
        bit [2:0] above = 0, sgn = 0, lhi, lneg;
        bit cond, deb, base_ea;
        int nxt, lim = int'(cfg_dbnc_limit);
        if (rst) begin
            m_cnt = 0; m_ea = 0; m_hi = 0; m_neg = 0;
            return;
        end
        for (int a = 0; a < 3; a++) begin
            logic [DW-1:0] s = (cfg_motion && cfg_use_hpf) ? hpf_smp[a] : raw_smp[a];
            above[a] = scaled_of(s) > int'(cfg_thresh);
            sgn[a]   = s[DW-1];
        end
        lhi  = above & cfg_axis_en;
        lneg = lhi & sgn;
        if (cfg_motion) cond = (lhi != 0);
        else            cond = (cfg_axis_en != 0) && (lhi == 0);
        if (cond)                nxt = (m_cnt < lim) ? m_cnt + 1 : lim;
        else if (cfg_dbnc_clear) nxt = 0;
        else                     nxt = (m_cnt > 0) ? m_cnt - 1 : 0;
        deb = cond && (nxt >= lim);
        if (cfg_latch && src_read) begin
            m_ea = 0; m_hi = 0; m_neg = 0;
        end
        base_ea = m_ea;
        if (smp_valid) begin
            m_cnt = nxt;
            if (!(cfg_latch && base_ea)) begin
                m_ea = deb; m_hi = lhi; m_neg = lneg;
            end
        end
    endtask

    task automatic check(input string tag);
        logic [7:0] act = {evt_active, axis_high, axis_neg, irq};
        logic [7:0] exp = {m_ea, m_hi, m_neg, m_ea};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {ea,high,neg,irq}=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; smp_valid = 1'b0; src_read = 1'b0;
        step("R12 reset held");
        rst = 1'b0;
        step("R12 reset state");
    endtask

    task automatic set_cfg(input bit mo, input bit hp, input bit [2:0] en, input int thr,
                           input bit la, input bit clr, input int lim);
        cfg_motion = mo; cfg_use_hpf = hp; cfg_axis_en = en; cfg_thresh = thr[TW-1:0];
        cfg_latch = la; cfg_dbnc_clear = clr; cfg_dbnc_limit = lim[CW-1:0];
    endtask

    task automatic sample(input int x, input int y, input int z, input string tag);
        raw_smp[0] = x[DW-1:0]; raw_smp[1] = y[DW-1:0]; raw_smp[2] = z[DW-1:0];
        smp_valid = 1'b1;
        step(tag);
        smp_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // threshold 10 -> boundary magnitude 640 (low) / 704 (high)
        set_cfg(1, 0, 3'b001, 10, 0, 1, 0);
        sample(640, 0, 0, "R2 equal is low");
        sample(704, 0, 0, "R2 above threshold");
        sample(-704, 0, 0, "R5 negative polarity");
        sample(-640, 0, 0, "R2 negative equal is low");
        sample(-8192, 0, 0, "R2 most negative code");
        sample(0, 8000, -8000, "R1 disabled axes ignored");
        set_cfg(1, 0, 3'b111, 10, 0, 1, 0);
        sample(0, 0, -704, "R3 motion any axis");
        set_cfg(0, 0, 3'b111, 10, 0, 1, 0);
        sample(100, -200, 640, "R3 freefall all low");
        sample(100, -200, 704, "R3 freefall one high");
        set_cfg(0, 0, 3'b011, 10, 0, 1, 0);
        sample(100, -200, 704, "R1 freefall skips disabled");
        set_cfg(0, 0, 3'b000, 10, 0, 1, 0);
        sample(0, 0, 0, "R3 no axis enabled");

        set_cfg(1, 1, 3'b001, 10, 0, 1, 0);
        hpf_smp[0] = 14'd0;
        sample(5000, 0, 0, "R4 motion takes filtered");
        hpf_smp[0] = 14'd5000;
        sample(0, 0, 0, "R4 motion filtered high");
        set_cfg(0, 1, 3'b111, 10, 0, 1, 0);
        sample(0, 0, 0, "R4 freefall uses raw");
        hpf_smp = '0;

        do_reset();
        set_cfg(1, 0, 3'b001, 10, 0, 1, 3);
        sample(704, 0, 0, "R8 first");
        sample(704, 0, 0, "R8 second");
        sample(0, 0, 0, "R9 miss clears");
        sample(704, 0, 0, "R9 restart one");
        sample(704, 0, 0, "R9 restart two");
        sample(704, 0, 0, "R8 third consecutive");

        do_reset();
        set_cfg(1, 0, 3'b001, 10, 0, 0, 3);
        sample(704, 0, 0, "R10 one");
        sample(704, 0, 0, "R10 two");
        sample(0, 0, 0, "R10 miss decrements");
        sample(704, 0, 0, "R10 back to two");
        sample(704, 0, 0, "R10 event after decrement");
        for (int i = 0; i < 5; i++) sample(704, 0, 0, "R10 saturate");
        sample(0, 0, 0, "R10 miss from limit");
        sample(704, 0, 0, "R10 saturated recovery");
        for (int i = 0; i < 4; i++) sample(0, 0, 0, "R10 floor at zero");
        sample(704, 0, 0, "R10 floor one");
        sample(704, 0, 0, "R10 floor two");
        sample(704, 0, 0, "R10 floor event");

        do_reset();
        set_cfg(1, 0, 3'b001, 10, 1, 1, 0);
        sample(-704, 0, 0, "R7 latch event");
        sample(0, 0, 0, "R7 hold on miss");
        sample(704, 0, 0, "R7 polarity frozen");
        src_read = 1'b1; step("R7 read clears"); src_read = 1'b0;
        sample(-704, 0, 0, "R7 relatch");
        src_read = 1'b1; sample(704, 0, 0, "R7 read with sample"); src_read = 1'b0;
        set_cfg(1, 0, 3'b001, 10, 0, 1, 0);
        sample(704, 0, 0, "R6 tracking event");
        src_read = 1'b1; step("R6 read ignored"); src_read = 1'b0;
        for (int i = 0; i < 3; i++) step("R13 idle hold");
        sample(0, 0, 0, "R11 irq follows event");

        for (int blk = 0; blk < 100; blk++) begin
            set_cfg($urandom % 2, $urandom % 2, $urandom % 8, $urandom % 128,
                    $urandom % 2, $urandom % 2, $urandom % 5);
            for (int i = 0; i < 25; i++) begin
                for (int a = 0; a < 3; a++) begin
                    int m = int'(cfg_thresh) * 64 + int'($urandom % 256) - 128;
                    int h = int'($urandom % 8192);
                    if (m < 0) m = 0;
                    if (m > 8191) m = 8191;
                    if ($urandom % 2) m = -m;
                    if ($urandom % 2) h = -h;
                    raw_smp[a] = m[DW-1:0];
                    hpf_smp[a] = h[DW-1:0];
                end
                smp_valid = ($urandom % 4) != 0;
                src_read  = ($urandom % 8) == 0;
                step("R3 random mix");
            end
            smp_valid = 1'b0; src_read = 1'b0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule